// File: doc/BRIEF.md
# Serial-to-Parallel Converter with Bit Slip

This block turns a serial bit stream, clocked at the bit rate, into 4-bit parallel words. One of two serial inputs is chosen as the data source, so a transmitter's output can be looped back for link testing. Each clock shifts the chosen bit into a four-stage register. At every word boundary the register is copied into a parallel output latch, and the latch then holds its value until the next boundary.

A local divider sets the word boundary and also drives two clock outputs, one at a quarter and one at an eighth of the bit clock. An asynchronous alignment request passes through a synchronizer. Each rising edge of that request makes the divider skip one count, which moves the word framing one bit later in the stream. In cascade mode the latch updates only on every second boundary. A serial output forwards the stream four bits late, so a second unit fed from it can supply the other half of an 8-bit word.

Top module: `s2p_deser4`

## Requirements
- R1: In every captured word, the earliest of the four bits lands on `par_o[0]` and the latest on `par_o[3]`.
- R2: With `mode_i` low, `load_o` pulses for one cycle every 4 clocks, always while `div4_o` is high, and `par_o` takes the new word on the clock edge that ends the pulse.
- R3: With `mode_i` high, `par_o` updates only on every second quarter-rate boundary, namely the boundaries where `div8_o` is high, which gives one update per 8 clocks.
- R4: `div4_o` is high for the last two counts of each 4-count cycle. `div8_o` toggles on each falling edge of `div4_o` and at no other time.
- R5: A rising edge on `sync_i` is sampled through two flops. The third clock edge after that rise leaves the divider unchanged: no load, and the phase does not advance. After that, every captured word starts one bit later in the stream, so a bit that was on `par_o[n]` now appears on `par_o[n-1]`.
- R6: Holding `sync_i` high for any length of time gives exactly one slip. A further slip needs `sync_i` to go low and rise again.
- R7: When `sel_i` is 1, `sin_a_i` is the serial source. When `sel_i` is 0, `sin_b_i` is the source, and the unselected input has no effect on any output.
- R8: After the clock edge that samples bit n, `sout_o` carries bit n-3, a delay of four bits.
- R9: An asynchronous active-low reset clears the shift register, the output latch, the divider count and the cascade phase. This drives `par_o`, `div4_o`, `div8_o` and `sout_o` to 0.
- R10: Outside the clock edge that ends a `load_o` pulse, `par_o` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit-rate clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Source select: 1 selects A, 0 selects B |
| sin_a_i | input | 1 | Serial input A (loopback path) |
| sin_b_i | input | 1 | Serial input B |
| mode_i | input | 1 | 0: update every 4 clocks; 1: update every 8 clocks (cascade) |
| sync_i | input | 1 | Asynchronous alignment slip request |
| par_o | output | 4 | Parallel word, earliest bit on bit 0 |
| div4_o | output | 1 | Bit clock divided by 4 |
| div8_o | output | 1 | Bit clock divided by 8 |
| sout_o | output | 1 | Serial stream delayed four bits, for cascading |
| load_o | output | 1 | One-cycle strobe before the latch captures |

## Verification
The two functions that can land in the same cycle are a swallowed divider count and a word boundary. A slip can fall on the last count of a word, and the load must then be suppressed and the boundary delayed by one clock. The bench provokes this by starting alignment pulses at each of the four divider phases in turn, in both conversion modes, and also by random pulse placement. In every cycle it compares the parallel word, both divided clocks, the load strobe and the forwarded bit against a model built from the bit history and the phase rules above.

// File: rtl/s2p_pkg.sv
package s2p_pkg;
  parameter int unsigned DefWordW   = 4;
  parameter int unsigned DefSyncStg = 2;

  typedef enum logic {
    CONV_X1 = 1'b0,  // update each divider wrap
    CONV_X2 = 1'b1   // update every second wrap
  } conv_mode_e;
endpackage

// File: rtl/s2p_sync_edge.sv
module s2p_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic pulse_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], async_i};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign pulse_o = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/s2p_divider.sv
module s2p_divider
  import s2p_pkg::*;
#(
  parameter int unsigned WORD_W = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       slip_i,
  input  conv_mode_e mode_i,
  output logic       div4_o,
  output logic       div8_o,
  output logic       load_o
);
  localparam int unsigned CntW = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam logic [CntW-1:0] LastCnt = CntW'(WORD_W - 1);

  logic [CntW-1:0] cnt_q;
  logic            half_q;
  logic            wrap;

  assign wrap = (cnt_q == LastCnt) && !slip_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      half_q <= 1'b0;
    end else if (!slip_i) begin
      if (wrap) begin
        cnt_q  <= '0;
        half_q <= ~half_q;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign div4_o = cnt_q[CntW-1];
  assign div8_o = half_q;
  assign load_o = wrap && ((mode_i == CONV_X1) || half_q);
endmodule

// File: rtl/s2p_shift_capture.sv
module s2p_shift_capture #(
  parameter int unsigned WORD_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_i,
  input  logic              load_i,
  output logic [WORD_W-1:0] par_o,
  output logic              sout_o
);
  logic [WORD_W-1:0] sr_q;
  logic [WORD_W-1:0] sr_d;
  logic [WORD_W-1:0] par_q;

  // newest bit enters at the top, oldest sits at bit 0
  assign sr_d = {bit_i, sr_q[WORD_W-1:1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q  <= '0;
      par_q <= '0;
    end else begin
      sr_q <= sr_d;
      if (load_i) par_q <= sr_d;
    end
  end

  assign par_o  = par_q;
  assign sout_o = sr_q[0];
endmodule

// File: rtl/s2p_deser4.sv
module s2p_deser4
  import s2p_pkg::*;
#(
  parameter int unsigned WORD_W   = DefWordW,
  parameter int unsigned SYNC_STG = DefSyncStg
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              sin_a_i,
  input  logic              sin_b_i,
  input  logic              mode_i,
  input  logic              sync_i,
  output logic [WORD_W-1:0] par_o,
  output logic              div4_o,
  output logic              div8_o,
  output logic              sout_o,
  output logic              load_o
);
  logic       ser_bit;
  logic       slip;
  conv_mode_e conv_mode;

  assign ser_bit   = sel_i ? sin_a_i : sin_b_i;
  assign conv_mode = conv_mode_e'(mode_i);

  s2p_sync_edge #(.STAGES(SYNC_STG)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(sync_i),
    .pulse_o(slip)
  );

  s2p_divider #(.WORD_W(WORD_W)) i_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .slip_i(slip),
    .mode_i(conv_mode),
    .div4_o(div4_o),
    .div8_o(div8_o),
    .load_o(load_o)
  );

  s2p_shift_capture #(.WORD_W(WORD_W)) i_cap (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .bit_i (ser_bit),
    .load_i(load_o),
    .par_o (par_o),
    .sout_o(sout_o)
  );
endmodule

// File: rtl/s2p_deser4_chk.sv
module s2p_deser4_chk #(
  parameter int unsigned WORD_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mode_i,
  input logic              slip_i,
  input logic              load_o,
  input logic              div4_o,
  input logic              div8_o,
  input logic [WORD_W-1:0] par_o
);
  AST_PAR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_o |=> $stable(par_o)); // R10

  AST_LOAD_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> !load_o); // R2

  AST_LOAD_IN_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |-> div4_o); // R2

  AST_CASCADE_ALT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_o && mode_i) |-> div8_o); // R3

  AST_DIV8_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(div4_o) |-> (div8_o != $past(div8_o))); // R4

  AST_DIV8_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$fell(div4_o) |-> $stable(div8_o)); // R4

  AST_SLIP_NO_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slip_i |-> !load_o); // R5

  AST_SLIP_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slip_i |=> ($stable(div4_o) && $stable(div8_o))); // R5

  AST_SLIP_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slip_i |=> !slip_i); // R6
endmodule

bind s2p_deser4 s2p_deser4_chk #(.WORD_W(WORD_W)) i_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .mode_i(mode_i),
  .slip_i(slip),
  .load_o(load_o),
  .div4_o(div4_o),
  .div8_o(div8_o),
  .par_o (par_o)
);

// File: tb/test_s2p_deser4.sv
module test_s2p_deser4;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sel_i = 1'b0, sin_a_i = 1'b0, sin_b_i = 1'b0, mode_i = 1'b0, sync_i = 1'b0;
  logic [3:0] par_o;
  logic div4_o, div8_o, sout_o, load_o;

  always #10 clk = ~clk;

  s2p_deser4 i_s2p_deser4 (
    .clk_i(clk), .rst_ni(rst_ni), .sel_i(sel_i), .sin_a_i(sin_a_i),
    .sin_b_i(sin_b_i), .mode_i(mode_i), .sync_i(sync_i), .par_o(par_o),
    .div4_o(div4_o), .div8_o(div8_o), .sout_o(sout_o), .load_o(load_o)
  );

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  string tag = "R9";

  // requirement-level model
  logic [3:0] m_h;    // m_h[0] newest sampled bit
  int         m_cnt;
  logic       m_p8;
  logic [2:0] m_sp;   // two sampling flops plus edge memory
  logic [3:0] m_par;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_h = '0; m_cnt = 0; m_p8 = 1'b0; m_sp = '0; m_par = '0;
    end else begin
      logic b, sl;
      b  = sel_i ? sin_a_i : sin_b_i;
      sl = m_sp[1] & ~m_sp[2];
      m_h = {m_h[2:0], b};
      if (!sl) begin
        if (m_cnt == 3) begin
          if (!mode_i || m_p8) m_par = {m_h[0], m_h[1], m_h[2], m_h[3]};
          m_p8 = ~m_p8;
          m_cnt = 0;
        end else m_cnt++;
      end
      m_sp = {m_sp[1:0], sync_i};
    end
  end

  always @(posedge clk) cycles++;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic check_all();
    logic e_load;
    e_load = (m_cnt == 3) && !(m_sp[1] & ~m_sp[2]) && (!mode_i || m_p8);
    chk(par_o === m_par, tag, "par", par_o, m_par);
    chk(div4_o === (m_cnt >= 2), "R4", "div4", {3'b0, div4_o}, {3'b0, m_cnt >= 2});
    chk(div8_o === m_p8, "R4", "div8", {3'b0, div8_o}, {3'b0, m_p8});
    chk(sout_o === m_h[3], "R8", "sout", {3'b0, sout_o}, {3'b0, m_h[3]});
    chk(load_o === e_load, mode_i ? "R3" : "R2", "load", {3'b0, load_o}, {3'b0, e_load});
  endtask

  task automatic step(input logic sel, input logic a, input logic b,
                      input logic mode, input logic sync);
    @(negedge clk);
    check_all();
    sel_i = sel; sin_a_i = a; sin_b_i = b; mode_i = mode; sync_i = sync;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    tag = "R9";
    repeat (3) begin
      @(negedge clk);
      chk(par_o === 4'h0, "R9", "par reset", par_o, 4'h0);
      chk({div4_o, div8_o, sout_o} === 3'b000, "R9", "div/sout reset",
          {1'b0, div4_o, div8_o, sout_o}, 4'h0);
    end
    rst_ni = 1'b1;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    void'($urandom(32'd7411));
    do_reset();

    // R1: marker bit at word start, A selected
    tag = "R1";
    for (int i = 0; i < 32; i++) step(1'b1, (i % 4) == 0, $urandom % 2, 1'b0, 1'b0);
    for (int i = 0; i < 32; i++) step(1'b1, (i % 4) == 2, $urandom % 2, 1'b0, 1'b0);

    // R7: B selected, noise on A
    tag = "R7";
    for (int i = 0; i < 48; i++) step(1'b0, $urandom % 2, (i % 3) == 0, 1'b0, 1'b0);

    // R3: cascade rate
    tag = "R3";
    for (int i = 0; i < 64; i++) step(1'b1, $urandom % 2, 1'b0, 1'b1, 1'b0);

    // R5: slip pulses started at each phase, both modes (covers slip on boundary)
    tag = "R5";
    for (int m = 0; m < 2; m++)
      for (int ph = 0; ph < 4; ph++) begin
        for (int i = 0; i < ph + 3; i++) step(1'b1, $urandom % 2, 1'b0, m[0], 1'b0);
        step(1'b1, $urandom % 2, 1'b0, m[0], 1'b1);
        step(1'b1, $urandom % 2, 1'b0, m[0], 1'b1);
        for (int i = 0; i < 12; i++) step(1'b1, $urandom % 2, 1'b0, m[0], 1'b0);
      end

    // R6: long hold gives a single slip
    tag = "R6";
    for (int i = 0; i < 40; i++) step(1'b1, $urandom % 2, 1'b0, 1'b0, 1'b1);
    for (int i = 0; i < 16; i++) step(1'b1, $urandom % 2, 1'b0, 1'b0, 1'b0);

    // R10: constrained random traffic
    tag = "R10";
    begin
      int run = 0;
      logic s = 1'b0, md = 1'b0;
      for (int i = 0; i < 4000; i++) begin
        if (run == 0) begin s = ~s; run = 2 + ($urandom % 9); end
        run--;
        if (($urandom % 200) == 0) md = ~md;
        step($urandom % 2, $urandom % 2, $urandom % 2, md, s);
      end
    end

    do_reset();
    tag = "R10";
    for (int i = 0; i < 40; i++) step($urandom % 2, $urandom % 2, $urandom % 2, 1'b0, 1'b0);

    finish_run();
  end

  initial begin
    wait (cycles > 150000);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
    finish_run();
  end
endmodule